// File: doc/BRIEF.md
# Hyperbolic CORDIC Exponential and Hyperbolic Tangent Unit

This block is a fixed-point arithmetic unit. It evaluates either e^x or tanh(x) for a signed operand. The operand is split into a floored integer part k and a non-negative fraction f, so that x = k + f. The value e^k is read from a table that is built when the design elaborates. The value e^f comes from an iterative hyperbolic CORDIC engine that uses only shifts, adds and a per-step angle table. The two factors are multiplied to give the exponential. Integer parts outside the table saturate the result to zero or to the largest code.

In tanh mode the operand is first doubled with a one-bit left shift. The exponential E = e^(2x) is then formed on the same path. A sequential restoring divider produces |E − 1| / (E + 1), and the sign is applied afterwards. A one-cycle `start` pulse captures the operand and the mode. `busy` covers the whole operation, and `done` marks the single cycle in which `result` first holds the answer.

The controller has six states:
- IDLE waits for `start`.
- SPLIT latches k and f, loads the CORDIC engine and decides on saturation.
- ROTATE steps the engine.
- SCALE multiplies, or substitutes the saturated value.
- DIVIDE runs the divider (tanh mode only).
- FINISH raises `done`.

Its transitions are:
- IDLE→SPLIT on `start`.
- SPLIT→ROTATE when k is in range, and SPLIT→SCALE when it is not.
- ROTATE→SCALE when the engine has finished its steps.
- SCALE→FINISH in exp mode, and SCALE→DIVIDE in tanh mode.
- DIVIDE→FINISH when the quotient is complete.
- FINISH→IDLE always.

Top module: `hexp_unit`

## Requirements
- R1: With `mode`=0 (exp), `result` is an unsigned Q24.16 value within 4 LSB + 2e-6·expected of e^x·2^16, for any operand whose integer part floor(x) lies in −16..15.
- R2: `operand` is signed two's-complement Q8.16 (bit 23 sign, 16 fraction bits). The integer part is floor(x), so negative non-integer operands such as −0.5 and −2.25 meet R1.
- R3: R1 accuracy holds across the whole fraction range [0,1), including fractions just below 1. The hyperbolic iterations start at shift 1 and run shifts 4 and 13 twice.
- R4: In exp mode, floor(x) > 15 gives `result` = 40'hFF_FFFF_FFFF.
- R5: In exp mode, floor(x) < −16 gives `result` = 0.
- R6: With `mode`=1 (tanh), `result` is a 40-bit two's-complement Q.16 value within 4 LSB of tanh(x)·2^16. It is computed from E = e^(2x) as in R1.
- R7: In tanh mode, floor(2x) > 15 gives exactly 65535, and floor(2x) < −16 gives exactly −65536.
- R8: `busy` is high from the cycle after `start` is sampled until `done`. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R9: A `start` pulse while `busy` is high is ignored. The result belongs to the first operand, and no extra `done` follows.
- R10: After reset, `busy`=0, `done`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; captures `mode` and `operand` when idle |
| mode | input | 1 | 0 = exponential, 1 = hyperbolic tangent |
| operand | input | 24 | Signed Q8.16 argument |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 40 | Unsigned Q24.16 exp, or signed Q.16 tanh |

## Verification
The bench targets negative fractional operands. A split that truncated toward zero instead of flooring would be off by a factor of e there. Fractions just under one probe whether the repeated iterations are present; without them the engine fails to converge and the result is off by parts in a thousand. The saturation edges are tested at −16 and −16.5, at 15.99998 and 16, and at ±10 in tanh mode. An off-by-one in the range check would either read a table entry that does not exist or clip a value that is still legal. A second `start` is issued mid-operation: a controller that restarted would return e^5 instead of tanh(0.5), or pulse `done` twice.

// File: rtl/hexp_pkg.sv
package hexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_ROTATE,
        ST_SCALE,
        ST_DIVIDE,
        ST_FINISH
    } state_t;

    typedef enum logic {
        OP_EXP  = 1'b0,
        OP_TANH = 1'b1
    } op_t;

    // Shift amount used by CORDIC step s: shifts 1,2,3,4,4,5..13,13,14,...
    function automatic int shift_of(input int s);
        if (s <= 3)       return s + 1;
        else if (s <= 13) return s;
        else              return s - 1;
    endfunction

    function automatic real atanh_r(input real t);
        return 0.5 * $ln((1.0 + t) / (1.0 - t));
    endfunction

    // Reciprocal of the hyperbolic gain over the given number of steps.
    function automatic real inv_gain(input int steps);
        real g;
        g = 1.0;
        for (int s = 0; s < steps; s++) begin
            g = g * $sqrt(1.0 - 1.0 / (4.0 ** shift_of(s)));
        end
        return 1.0 / g;
    endfunction

endpackage

// File: rtl/hexp_int_table.sv
module hexp_int_table #(
    parameter int FRAC_W = 16,
    parameter int RES_W  = 40,
    parameter int INT_LO = -16,
    parameter int INT_HI = 15,
    parameter int K_W    = 9
) (
    input  logic signed [K_W-1:0]   k,
    output logic        [RES_W-1:0] value
);
    localparam int DEPTH = INT_HI - INT_LO + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SLOTS = 1 << IDX_W;

    logic [RES_W-1:0] rom [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_rom
        if (g < DEPTH) begin : g_used
            localparam logic [RES_W-1:0] ENTRY =
                RES_W'(longint'($exp(real'(g + INT_LO)) * (2.0 ** FRAC_W)));
            assign rom[g] = ENTRY;
        end else begin : g_pad
            assign rom[g] = '0;
        end
    end

    int offset;

    always_comb begin
        offset = int'(k) - INT_LO;
        if (offset >= 0 && offset < DEPTH)
            value = rom[IDX_W'(offset)];
        else
            value = '0;
    end

endmodule

// File: rtl/hexp_cordic.sv
module hexp_cordic
    import hexp_pkg::*;
#(
    parameter int CW        = 32,
    parameter int CFRAC     = 28,
    parameter int FRAC_W    = 16,
    parameter int MAX_SHIFT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              finished,
    output logic [CW-1:0]     exp_frac
);
    localparam int STEPS = MAX_SHIFT + 2;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int SLOTS = 1 << CNT_W;
    localparam logic signed [CW-1:0] X_INIT =
        CW'(longint'(inv_gain(STEPS) * (2.0 ** CFRAC)));
    localparam logic signed [CW-1:0] Z_LIMIT =
        CW'(longint'(2.0 ** (CFRAC - MAX_SHIFT + 1)));

    logic signed [CW-1:0] ang_rom [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_ang
        if (g < STEPS) begin : g_used
            localparam logic signed [CW-1:0] ANG =
                CW'(longint'(atanh_r(1.0 / (2.0 ** shift_of(g))) * (2.0 ** CFRAC)));
            assign ang_rom[g] = ANG;
        end else begin : g_pad
            assign ang_rom[g] = '0;
        end
    end

    logic signed [CW-1:0] x_q, y_q, z_q;
    logic signed [CW-1:0] x_n, y_n, z_n, x_sh, y_sh, ang;
    logic [CNT_W-1:0]     cnt_q;
    int                   sh;

    always_comb begin
        sh   = shift_of(int'(cnt_q));
        x_sh = x_q >>> sh;
        y_sh = y_q >>> sh;
        ang  = ang_rom[cnt_q];
        if (!z_q[CW-1]) begin
            x_n = x_q + y_sh;
            y_n = y_q + x_sh;
            z_n = z_q - ang;
        end else begin
            x_n = x_q - y_sh;
            y_n = y_q - x_sh;
            z_n = z_q + ang;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            z_q   <= '0;
            cnt_q <= CNT_W'(STEPS);
        end else if (load) begin
            x_q   <= X_INIT;
            y_q   <= '0;
            z_q   <= CW'(frac_in) <<< (CFRAC - FRAC_W);
            cnt_q <= '0;
        end else if (step && cnt_q < CNT_W'(STEPS)) begin
            x_q   <= x_n;
            y_q   <= y_n;
            z_q   <= z_n;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign finished = (cnt_q == CNT_W'(STEPS));
    assign exp_frac = x_q + y_q;

    // R3: the step counter never runs past the last step
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(STEPS));

    // R3: once all steps are done the residual angle has converged
    a_r3_residual_small: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (z_q <= Z_LIMIT && z_q >= -Z_LIMIT));

endmodule

// File: rtl/hexp_divider.sv
module hexp_divider #(
    parameter int NUM_W = 41,
    parameter int QUO_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [NUM_W-1:0] den,
    output logic             finished,
    output logic [QUO_W-1:0] quo
);
    localparam int REM_W = NUM_W + 2;
    localparam int CNT_W = $clog2(QUO_W + 1);

    logic [REM_W-1:0] rem_q, den_q;
    logic [QUO_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fits;

    assign fits = (rem_q >= den_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            quo_q <= '0;
            cnt_q <= CNT_W'(QUO_W);
        end else if (load) begin
            rem_q <= REM_W'(num);
            den_q <= REM_W'(den);
            quo_q <= '0;
            cnt_q <= '0;
        end else if (cnt_q < CNT_W'(QUO_W)) begin
            rem_q <= (fits ? (rem_q - den_q) : rem_q) << 1;
            quo_q <= {quo_q[QUO_W-2:0], fits};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign finished = (cnt_q == CNT_W'(QUO_W));
    assign quo      = quo_q;

    // R6: partial remainder stays below twice the divisor while running
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_W'(QUO_W)) |-> (rem_q < (den_q << 1)));

endmodule

// File: rtl/hexp_unit.sv
module hexp_unit
    import hexp_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int FRAC_W    = 16,
    parameter int RES_W     = 40,
    parameter int INT_LO    = -16,
    parameter int INT_HI    = 15,
    parameter int CW        = 32,
    parameter int CFRAC     = 28,
    parameter int MAX_SHIFT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  result
);
    localparam int EXT_W  = DATA_W + 1;
    localparam int K_W    = EXT_W - FRAC_W;
    localparam int NUM_W  = RES_W + 1;
    localparam int QUO_W  = FRAC_W + 1;
    localparam int PROD_W = RES_W + CW;
    localparam logic [RES_W-1:0] ONE_FX  = RES_W'(1) << FRAC_W;
    localparam logic [RES_W-1:0] SAT_MAX = '1;

    state_t                   state_q, state_d;
    op_t                      op_q;
    logic signed [DATA_W-1:0] arg_q;
    logic signed [K_W-1:0]    k_q;
    logic                     sat_hi_q, sat_lo_q, neg_q;
    logic [RES_W-1:0]         result_q;

    logic signed [EXT_W-1:0]  arg_ext;
    logic signed [K_W-1:0]    k_now;
    logic [FRAC_W-1:0]        frac_now;
    logic                     k_over, k_under;

    logic [RES_W-1:0]         tbl_val;
    logic [CW-1:0]            cordic_val;
    logic                     cordic_fin;
    logic [PROD_W-1:0]        prod;
    logic [RES_W-1:0]         e_prod, e_val;
    logic                     prod_ovf;

    logic [NUM_W-1:0]         div_num, div_den;
    logic [QUO_W-1:0]         div_quo;
    logic                     div_fin;

    // Split: doubling for tanh is a one-bit left shift
    always_comb begin
        if (op_q == OP_TANH) arg_ext = {arg_q, 1'b0};
        else                 arg_ext = {arg_q[DATA_W-1], arg_q};
        k_now    = arg_ext[EXT_W-1:FRAC_W];
        frac_now = arg_ext[FRAC_W-1:0];
        k_over   = (k_now > INT_HI);
        k_under  = (k_now < INT_LO);
    end

    hexp_int_table #(
        .FRAC_W (FRAC_W),
        .RES_W  (RES_W),
        .INT_LO (INT_LO),
        .INT_HI (INT_HI),
        .K_W    (K_W)
    ) u_table (
        .k     (k_q),
        .value (tbl_val)
    );

    hexp_cordic #(
        .CW        (CW),
        .CFRAC     (CFRAC),
        .FRAC_W    (FRAC_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_cordic (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_SPLIT),
        .step     (state_q == ST_ROTATE),
        .frac_in  (frac_now),
        .finished (cordic_fin),
        .exp_frac (cordic_val)
    );

    // Scale: e^k * e^f, or the saturated code
    always_comb begin
        prod     = PROD_W'(tbl_val) * PROD_W'(cordic_val);
        e_prod   = RES_W'(prod >> CFRAC);
        prod_ovf = |(prod >> (CFRAC + RES_W));
        if (sat_hi_q || prod_ovf) e_val = SAT_MAX;
        else if (sat_lo_q)        e_val = '0;
        else                      e_val = e_prod;
        if (e_val >= ONE_FX) div_num = NUM_W'(e_val - ONE_FX);
        else                 div_num = NUM_W'(ONE_FX - e_val);
        div_den = NUM_W'(e_val) + NUM_W'(ONE_FX);
    end

    hexp_divider #(
        .NUM_W (NUM_W),
        .QUO_W (QUO_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_SCALE && op_q == OP_TANH),
        .num      (div_num),
        .den      (div_den),
        .finished (div_fin),
        .quo      (div_quo)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SPLIT;
            ST_SPLIT:  state_d = (k_over || k_under) ? ST_SCALE : ST_ROTATE;
            ST_ROTATE: if (cordic_fin) state_d = ST_SCALE;
            ST_SCALE:  state_d = (op_q == OP_TANH) ? ST_DIVIDE : ST_FINISH;
            ST_DIVIDE: if (div_fin) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_EXP;
            arg_q    <= '0;
            k_q      <= '0;
            sat_hi_q <= 1'b0;
            sat_lo_q <= 1'b0;
            neg_q    <= 1'b0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q  <= op_t'(mode);
                    arg_q <= operand;
                end
                ST_SPLIT: begin
                    k_q      <= k_now;
                    sat_hi_q <= k_over;
                    sat_lo_q <= k_under;
                end
                ST_SCALE: begin
                    neg_q <= (e_val < ONE_FX);
                    if (op_q == OP_EXP) result_q <= e_val;
                end
                ST_DIVIDE: if (div_fin) begin
                    if (neg_q) result_q <= RES_W'(0) - RES_W'(div_quo);
                    else       result_q <= RES_W'(div_quo);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        result = result_q;
    end

    // R8: done is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the unit is idle right after done
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: tanh results stay within [-1, +1]
    a_r6_tanh_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_TANH) |->
            ($signed(result_q) <= $signed(ONE_FX) && $signed(result_q) >= -$signed(ONE_FX)));

    // R4: an over-range integer part in exp mode yields the top code
    a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_EXP && sat_hi_q) |-> (result_q == SAT_MAX));

    // R5: an under-range integer part in exp mode yields zero
    a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_EXP && sat_lo_q) |-> (result_q == '0));

endmodule

// File: tb/hexp_unit_bench.sv
module hexp_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [23:0] operand = '0;
    logic        busy, done;
    logic [39:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    hexp_unit u_hexp_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode    (mode),
        .operand (operand),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    // {mode, Q8.16 operand}
    localparam int N_VEC = 17;
    localparam logic [24:0] VEC [N_VEC] = '{
        {1'b0, 24'h000000}, {1'b0, 24'h010000}, {1'b0, 24'hFF0000},
        {1'b0, 24'h008000}, {1'b0, 24'h02C000}, {1'b0, 24'h074CCD},
        {1'b0, 24'hFCCCCD}, {1'b0, 24'h0FFFFF}, {1'b0, 24'hF00000},
        {1'b0, 24'h0A2000},
        {1'b1, 24'h000000}, {1'b1, 24'h008000}, {1'b1, 24'hFF8000},
        {1'b1, 24'h014000}, {1'b1, 24'hFE0000}, {1'b1, 24'h030000},
        {1'b1, 24'h00199A}
    };

    task automatic check_close(input string tag, input real got, input real want, input real tol);
        n_checks++;
        if (got - want > tol || want - got > tol) begin
            n_fail++;
            $display("FAIL %s: got %f expected %f", tag, got, want);
        end
    endtask

    task automatic check_eq(input string tag, input logic [39:0] got, input logic [39:0] want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    function automatic real to_real(input logic [23:0] a);
        return real'($signed(a)) / 65536.0;
    endfunction

    function automatic real want_exp(input logic [23:0] a);
        return $exp(to_real(a)) * 65536.0;
    endfunction

    function automatic real want_tanh(input logic [23:0] a);
        real e;
        e = $exp(2.0 * to_real(a));
        return (e - 1.0) / (e + 1.0) * 65536.0;
    endfunction

    task automatic wait_done(output logic [39:0] r);
        int waited;
        waited = 0;
        while (!done && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8: done missing, got busy=%b expected done=1", busy);
        end
        r = result;
        @(negedge clk);
        check_eq("R8 done drops after one cycle and busy clears", {38'd0, done, busy}, 40'd0);
    endtask

    task automatic run_op(input logic m, input logic [23:0] a, output logic [39:0] r);
        @(negedge clk);
        mode    = m;
        operand = a;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R8 busy after start", {39'd0, busy}, 40'd1);
        wait_done(r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [39:0] r;
        real want;

        repeat (3) @(negedge clk);
        // R10: reset state
        check_eq("R10 reset outputs", {busy, done, 38'd0}, 40'd0);
        check_eq("R10 reset result", result, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 exp mode, R6 tanh mode
        for (int i = 0; i < N_VEC; i++) begin
            run_op(VEC[i][24], VEC[i][23:0], r);
            if (VEC[i][24] == 1'b0) begin
                want = want_exp(VEC[i][23:0]);
                check_close("R1 exp vector", real'(r), want, 4.0 + 2.0e-6 * want);
            end else begin
                want = want_tanh(VEC[i][23:0]);
                check_close("R6 tanh vector", real'($signed(r)), want, 4.0);
            end
        end

        // R2: negative operands with fractional parts (floored split)
        run_op(1'b0, 24'hFF8000, r);
        want = want_exp(24'hFF8000);
        check_close("R2 exp(-0.5)", real'(r), want, 4.0 + 2.0e-6 * want);
        run_op(1'b0, 24'hFDC000, r);
        want = want_exp(24'hFDC000);
        check_close("R2 exp(-2.25)", real'(r), want, 4.0 + 2.0e-6 * want);

        // R3: fractions at the top of the range
        run_op(1'b0, 24'h00FFFF, r);
        want = want_exp(24'h00FFFF);
        check_close("R3 exp(0.99998)", real'(r), want, 4.0 + 2.0e-6 * want);
        run_op(1'b0, 24'hFFFFFF, r);
        want = want_exp(24'hFFFFFF);
        check_close("R3 exp(-0.00002)", real'(r), want, 4.0 + 2.0e-6 * want);
        run_op(1'b0, 24'h04F000, r);
        want = want_exp(24'h04F000);
        check_close("R3 exp(4.9375)", real'(r), want, 4.0 + 2.0e-6 * want);

        // R4: upper saturation in exp mode
        run_op(1'b0, 24'h100000, r);
        check_eq("R4 exp(16.0) saturates", r, 40'hFF_FFFF_FFFF);
        run_op(1'b0, 24'h7FFFFF, r);
        check_eq("R4 exp(127.99) saturates", r, 40'hFF_FFFF_FFFF);

        // R5: lower saturation in exp mode
        run_op(1'b0, 24'hEF8000, r);
        check_eq("R5 exp(-16.5) is zero", r, 40'd0);
        run_op(1'b0, 24'h800000, r);
        check_eq("R5 exp(-128) is zero", r, 40'd0);

        // R7: tanh with doubled argument out of range
        run_op(1'b1, 24'h0A0000, r);
        check_eq("R7 tanh(10)", r, 40'd65535);
        run_op(1'b1, 24'hF60000, r);
        check_eq("R7 tanh(-10)", r, 40'hFF_FFFF_0000);
        run_op(1'b1, 24'h080000, r);
        check_eq("R7 tanh(8)", r, 40'd65535);

        // R9: second start while busy is ignored
        @(negedge clk);
        mode    = 1'b1;
        operand = 24'h008000;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        mode    = 1'b0;
        operand = 24'h050000;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(r);
        check_close("R9 result belongs to first operand", real'($signed(r)),
                    want_tanh(24'h008000), 4.0);
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 80; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check_eq("R9 no extra done", 40'(extra), 40'd0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule